// File: doc/BRIEF.md
# DPLL Operating Mode Controller

This block decides which operating mode a digital phase-locked loop is in while it follows a chosen input reference. It reads the status that the rest of the loop already produces: the size of the measured phase error, a 3-bit limit setting, whether a reference is valid and applied, whether the loop reports lock, whether a known-good standby source exists, the revertive enable, and a strobe raised when a higher-priority reference comes back. From these inputs it produces a 3-bit mode code, a one-cycle request to disqualify the current reference, and two controls for the loop. The first control holds the oscillator at its integral-path frequency. The second removes the proportional path.

All timeouts are counted in whole seconds. The count advances only on a one-cycle seconds tick that an external prescaler supplies. A test environment can therefore drive the tick directly and compress real time. There are two timeouts. A recovery timeout bounds the time the loop may spend trying to regain phase on the same reference. An acquisition timeout bounds the two pre-locked states. Both default to 100 seconds.

Mode codes: 0 Free-Run, 1 Pre-Locked, 2 Locked, 3 Lost-Phase, 4 Holdover, 5 Pre-Locked(2).

Top module: `dpll_mode_ctrl`

## Requirements
- R1: While reset is low at a clock edge, the mode becomes 0 (Free-Run), and the disqualify, freeze and proportional-disable outputs become 0.
- R2: From Free-Run, the mode becomes 1 (Pre-Locked) on the first clock edge at which the reference-valid input is high. It stays 0 while that input is low, and once left, Free-Run is not entered again without reset.
- R3: In mode 1 or mode 5, a high lock input moves the mode to 2 (Locked) at the next edge. Lock takes priority over an acquisition timeout that expires in the same cycle.
- R4: In mode 1 or mode 5 without lock, the mode moves to 4 (Holdover) on the edge that carries the ACQ_TIMEOUT_S-th seconds tick counted since the state was entered.
- R5: In Locked, the mode moves to 3 (Lost-Phase) when the phase error is strictly greater than (limit_sel + 1) * LIMIT_STEP, where LIMIT_STEP defaults to 32. An error equal to that threshold leaves the mode at Locked.
- R6: In Lost-Phase, the mode returns to Locked when the lock input is high and the phase error is at or below the threshold. The seconds count restarts on every new entry into Lost-Phase.
- R7: In Lost-Phase, the LOSS_TIMEOUT_S-th tick raises the disqualify output for exactly one cycle and moves the mode to 5 if the standby flag is high, or to 4 if it is low. A recovery in that same cycle wins: the mode goes to Locked and no pulse is raised.
- R8: In Locked, a low reference-valid input moves the mode to Holdover. This takes priority over revertive switching and over the phase-error check.
- R9: The freeze and proportional-disable outputs are both high exactly while the mode is Holdover.
- R10: In Holdover, a high reference-valid input moves the mode to 5 (Pre-Locked(2)) at the next edge.
- R11: In Locked with the revertive enable high, a high higher-priority-restored strobe moves the mode to 5. When the revertive enable is low, the strobe has no effect.
- R12: Seconds ticks are counted only in modes 1, 3 and 5. Ticks that arrive in any other mode do not shorten a later timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| phase_err | input | PE_W (12) | Magnitude of the measured phase error |
| limit_sel | input | 3 | Phase-error limit setting |
| ref_valid | input | 1 | Selected reference is valid and applied |
| lock_ind | input | 1 | Loop reports lock |
| standby_ok | input | 1 | A known-good standby source is available |
| revert_en | input | 1 | Revertive switching enabled |
| hp_restored | input | 1 | Strobe: higher-priority reference restored |
| mode | output | 3 | Current mode code |
| ref_disq | output | 1 | One-cycle reference-disqualify pulse |
| freq_freeze | output | 1 | Hold the oscillator at its integral-path frequency |
| prop_disable | output | 1 | Disable the proportional path |

## Verification
Two functions can fall in the same cycle in Lost-Phase: the recovery back to Locked and the expiry of the recovery timeout. The bench places 99 ticks in Lost-Phase and then drives the 100th tick in the same cycle that the phase error falls back within the limit while lock is high. It expects Locked with no disqualify pulse. The same kind of collision is arranged in Pre-Locked(2) between lock and the acquisition timeout, and in Locked between the loss of the reference, a revertive strobe and an out-of-limit error. A behavioural model in the bench computes the expected values, and the outputs are compared with that model on every clock.

// File: rtl/dpll_mode_pkg.sv
// Shared types for the DPLL mode controller.
// Assumes: the mode codes below are seen by software and neighbours,
// so their numeric values are fixed.
package dpll_mode_pkg;

    typedef enum logic [2:0] {
        MODE_FREE   = 3'd0,
        MODE_ACQ    = 3'd1,
        MODE_LOCKED = 3'd2,
        MODE_LOST   = 3'd3,
        MODE_HOLD   = 3'd4,
        MODE_REACQ  = 3'd5
    } mode_e;

endpackage

// File: rtl/dpll_err_cmp.sv
// Phase-error limit comparator.
// Builds the threshold (limit_sel + 1) * LIMIT_STEP and flags an error
// strictly above it. Purely combinational; assumes phase_err is a
// magnitude (unsigned) that is stable for the cycle it is sampled in.
module dpll_err_cmp #(
    parameter int PE_W       = 12,
    parameter int LIMIT_STEP = 32
) (
    input  logic [PE_W-1:0] phase_err,
    input  logic [2:0]      limit_sel,
    output logic            over_limit
);

    localparam int TH_W = PE_W + 4;

    logic [TH_W-1:0] thresh;

    // Threshold from the 3-bit setting, then strict comparison.
    always_comb begin
        thresh     = (TH_W'(limit_sel) + TH_W'(1)) * TH_W'(LIMIT_STEP);
        over_limit = TH_W'(phase_err) > thresh;
    end

endmodule

// File: rtl/dpll_sec_timer.sv
// Seconds timeout counter.
// Counts sec_tick pulses while 'run' is high and clears on 'restart' or
// when not running. 'expire' is high in the cycle of the limit-th tick.
// Assumes limit >= 1 and that limit changes only together with restart.
module dpll_sec_timer #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);

    logic [CNT_W-1:0] count_q;

    // Expiry decode: last tick of the window.
    always_comb begin
        expire = run && tick && (count_q == limit - CNT_W'(1));
    end

    // Tick counter, cleared on state entry and outside timed states.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run) begin
            count_q <= '0;
        end else if (tick) begin
            count_q <= count_q + CNT_W'(1);
        end
    end

    AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (count_q < limit)); // R12

    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!run) |-> (count_q == '0)); // R12

endmodule

// File: rtl/dpll_mode_fsm.sv
// Mode state machine for the DPLL.
// Decides the next mode from reference, lock, phase-error and timeout
// status, and registers the mode together with its loop controls and the
// disqualify pulse. Assumes the inputs are synchronous to clk.
module dpll_mode_fsm
    import dpll_mode_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ref_valid,
    input  logic  lock_ind,
    input  logic  over_limit,
    input  logic  standby_ok,
    input  logic  revert_en,
    input  logic  hp_restored,
    input  logic  expire,
    output mode_e state_q,
    output logic  timing,
    output logic  restart,
    output logic  use_loss_limit,
    output logic  disq_q,
    output logic  freeze_q,
    output logic  prop_dis_q
);

    mode_e state_d;
    logic  disq_d;

    // Next-mode decision with per-state priorities.
    always_comb begin
        state_d = state_q;
        disq_d  = 1'b0;
        unique case (state_q)
            MODE_FREE: begin
                if (ref_valid) state_d = MODE_ACQ;
            end
            MODE_ACQ, MODE_REACQ: begin
                if (lock_ind)    state_d = MODE_LOCKED;
                else if (expire) state_d = MODE_HOLD;
            end
            MODE_LOCKED: begin
                if (!ref_valid)                    state_d = MODE_HOLD;
                else if (revert_en && hp_restored) state_d = MODE_REACQ;
                else if (over_limit)               state_d = MODE_LOST;
            end
            MODE_LOST: begin
                if (lock_ind && !over_limit) begin
                    state_d = MODE_LOCKED;
                end else if (expire) begin
                    disq_d  = 1'b1;
                    state_d = standby_ok ? MODE_REACQ : MODE_HOLD;
                end
            end
            MODE_HOLD: begin
                if (ref_valid) state_d = MODE_REACQ;
            end
            default: state_d = MODE_FREE;
        endcase
    end

    // Timer controls derived from the current mode.
    always_comb begin
        timing         = (state_q == MODE_ACQ) || (state_q == MODE_REACQ)
                      || (state_q == MODE_LOST);
        restart        = (state_d != state_q);
        use_loss_limit = (state_q == MODE_LOST);
    end

    // Mode register and registered loop controls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= MODE_FREE;
            disq_q     <= 1'b0;
            freeze_q   <= 1'b0;
            prop_dis_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            disq_q     <= disq_d;
            freeze_q   <= (state_d == MODE_HOLD);
            prop_dis_q <= (state_d == MODE_HOLD);
        end
    end

    AST_DISQ_FROM_LOST: assert property (@(posedge clk) disable iff (!rst_n)
        disq_q |-> ($past(state_q) == MODE_LOST && state_q != MODE_LOST)); // R7

    AST_DISQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        disq_q |=> !disq_q); // R7

    AST_LOST_FROM_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_LOST && $past(state_q) != MODE_LOST)
            |-> $past(state_q) == MODE_LOCKED); // R5

    AST_NO_FREE_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) != MODE_FREE) |-> (state_q != MODE_FREE)); // R2

    AST_REACQ_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_REACQ && $past(state_q) != MODE_REACQ)
            |-> ($past(state_q) == MODE_LOCKED || $past(state_q) == MODE_HOLD
                 || $past(state_q) == MODE_LOST)); // R10

    AST_LOCKED_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_LOCKED && $past(state_q) != MODE_LOCKED)
            |-> $past(lock_ind)); // R3

endmodule

// File: rtl/dpll_mode_ctrl.sv
// DPLL operating mode controller, top level.
// Joins the phase-error comparator, the seconds timer and the mode state
// machine. Assumes sec_tick is a single-cycle pulse and every status
// input is synchronous to clk. Timeouts are in seconds (ticks).
module dpll_mode_ctrl #(
    parameter int PE_W           = 12,
    parameter int LIMIT_STEP     = 32,
    parameter int LOSS_TIMEOUT_S = 100,
    parameter int ACQ_TIMEOUT_S  = 100
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sec_tick,
    input  logic [PE_W-1:0] phase_err,
    input  logic [2:0]      limit_sel,
    input  logic            ref_valid,
    input  logic            lock_ind,
    input  logic            standby_ok,
    input  logic            revert_en,
    input  logic            hp_restored,
    output logic [2:0]      mode,
    output logic            ref_disq,
    output logic            freq_freeze,
    output logic            prop_disable
);

    import dpll_mode_pkg::*;

    localparam int MAX_TO = (LOSS_TIMEOUT_S > ACQ_TIMEOUT_S) ? LOSS_TIMEOUT_S : ACQ_TIMEOUT_S;
    localparam int CNT_W  = $clog2(MAX_TO + 1);

    logic             over_limit;
    logic             expire;
    logic             timing;
    logic             restart;
    logic             use_loss_limit;
    logic [CNT_W-1:0] limit;
    mode_e            state;

    dpll_err_cmp #(
        .PE_W       (PE_W),
        .LIMIT_STEP (LIMIT_STEP)
    ) u_cmp (
        .phase_err  (phase_err),
        .limit_sel  (limit_sel),
        .over_limit (over_limit)
    );

    // Timeout length chosen by the state being timed.
    always_comb begin
        limit = use_loss_limit ? CNT_W'(LOSS_TIMEOUT_S) : CNT_W'(ACQ_TIMEOUT_S);
    end

    dpll_sec_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (timing),
        .restart (restart),
        .tick    (sec_tick),
        .limit   (limit),
        .expire  (expire)
    );

    dpll_mode_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .ref_valid      (ref_valid),
        .lock_ind       (lock_ind),
        .over_limit     (over_limit),
        .standby_ok     (standby_ok),
        .revert_en      (revert_en),
        .hp_restored    (hp_restored),
        .expire         (expire),
        .state_q        (state),
        .timing         (timing),
        .restart        (restart),
        .use_loss_limit (use_loss_limit),
        .disq_q         (ref_disq),
        .freeze_q       (freq_freeze),
        .prop_dis_q     (prop_disable)
    );

    // Mode code out as a plain vector.
    always_comb begin
        mode = 3'(state);
    end

    AST_CONTROLS_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        freq_freeze == prop_disable); // R9

    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mode <= 3'd5); // R1

    AST_HOLD_AFTER_REF_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 3'd2 && !$past(ref_valid)) |-> mode == 3'd4); // R8

endmodule

// File: tb/dpll_mode_ctrl_test.sv
`timescale 1ns/1ps
module dpll_mode_ctrl_test;

    localparam int STEP = 32;
    localparam int TO_S = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick = 1'b0;
    logic [11:0] phase_err = '0;
    logic [2:0]  limit_sel = 3'd2;
    logic        ref_valid = 1'b0;
    logic        lock_ind = 1'b0;
    logic        standby_ok = 1'b0;
    logic        revert_en = 1'b0;
    logic        hp_restored = 1'b0;
    logic [2:0]  mode;
    logic        ref_disq;
    logic        freq_freeze;
    logic        prop_disable;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    dpll_mode_ctrl uut (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .phase_err(phase_err),
        .limit_sel(limit_sel), .ref_valid(ref_valid), .lock_ind(lock_ind),
        .standby_ok(standby_ok), .revert_en(revert_en), .hp_restored(hp_restored),
        .mode(mode), .ref_disq(ref_disq), .freq_freeze(freq_freeze),
        .prop_disable(prop_disable)
    );

    always #4 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model, advanced at each rising edge.
    int m_mode = 0;
    int m_cnt = 0;
    int m_disq = 0;
    always @(posedge clk) begin
        int nm, lim, thr;
        bit timed, over, exp_now;
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0; m_disq = 0;
        end else begin
            nm = m_mode;
            m_disq = 0;
            thr = (int'(limit_sel) + 1) * STEP;
            over = int'(phase_err) > thr;
            timed = (m_mode == 1 || m_mode == 3 || m_mode == 5);
            lim = TO_S;
            exp_now = timed && sec_tick && (m_cnt == lim - 1);
            case (m_mode)
                0: if (ref_valid) nm = 1;
                1, 5: if (lock_ind) nm = 2; else if (exp_now) nm = 4;
                2: if (!ref_valid) nm = 4;
                   else if (revert_en && hp_restored) nm = 5;
                   else if (over) nm = 3;
                3: if (lock_ind && !over) nm = 2;
                   else if (exp_now) begin m_disq = 1; nm = standby_ok ? 5 : 4; end
                4: if (ref_valid) nm = 5;
                default: nm = 0;
            endcase
            if (nm != m_mode || !timed) m_cnt = 0;
            else if (sec_tick) m_cnt++;
            m_mode = nm;
        end
    end

    function automatic string mode_tag(input int m);
        case (m)
            0: return "R2";
            1: return "R3";
            2: return "R5";
            3: return "R6";
            4: return "R9";
            default: return "R10";
        endcase
    endfunction

    // Compare with the model every cycle, away from the rising edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(mode_tag(m_mode), int'(mode), m_mode);
            check("R7 model disq", int'(ref_disq), m_disq);
            check("R9 model freeze", int'(freq_freeze), int'(m_mode == 4));
            check("R9 model prop", int'(prop_disable), int'(m_mode == 4));
        end
    end

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            sec_tick = 1'b1; step();
            sec_tick = 1'b0; step();
        end
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        step(3);
        // R1: reset values
        check("R1 mode", int'(mode), 0);
        check("R1 disq", int'(ref_disq), 0);
        check("R1 freeze", int'(freq_freeze), 0);
        rst_n = 1'b1;
        step(3);
        check("R2 stays free-run", int'(mode), 0);
        ticks(5); // R12: ticks outside timed states
        ref_valid = 1'b1; step();
        check("R2 to pre-locked", int'(mode), 1);
        // R4: acquisition timeout
        ticks(TO_S - 1);
        check("R4 before timeout", int'(mode), 1);
        ref_valid = 1'b0;
        ticks(1);
        check("R4 holdover", int'(mode), 4);
        check("R9 freeze", int'(freq_freeze), 1);
        check("R9 prop", int'(prop_disable), 1);
        step(3);
        ref_valid = 1'b1; step();
        check("R10 to pre-locked2", int'(mode), 5);
        check("R9 freeze off", int'(freq_freeze), 0);
        lock_ind = 1'b1; step();
        check("R3 locked", int'(mode), 2);
        ticks(10); // R12: Locked ignores ticks
        // R5: threshold boundary, limit_sel=2 -> 96
        phase_err = 12'd96; step(2);
        check("R5 equal stays", int'(mode), 2);
        phase_err = 12'd97; step();
        check("R5 lost-phase", int'(mode), 3);
        ticks(50);
        phase_err = 12'd0; step();
        check("R6 recover", int'(mode), 2);
        phase_err = 12'd200; step();
        check("R6 lost again", int'(mode), 3);
        ticks(TO_S - 1);
        check("R12 count restarted", int'(mode), 3);
        // R7 collision: recovery and timeout in one cycle
        sec_tick = 1'b1; phase_err = 12'd0; step();
        sec_tick = 1'b0;
        check("R7 recovery wins", int'(mode), 2);
        check("R7 no disq", int'(ref_disq), 0);
        phase_err = 12'd200; step();
        lock_ind = 1'b0; standby_ok = 1'b1;
        ticks(TO_S - 1);
        sec_tick = 1'b1; step(); sec_tick = 1'b0;
        check("R7 standby", int'(mode), 5);
        check("R7 disq pulse", int'(ref_disq), 1);
        step();
        check("R7 disq single", int'(ref_disq), 0);
        phase_err = 12'd0; lock_ind = 1'b1; step();
        check("R3 relock", int'(mode), 2);
        phase_err = 12'd200; standby_ok = 1'b0; step();
        lock_ind = 1'b0;
        ticks(TO_S - 1);
        sec_tick = 1'b1; step(); sec_tick = 1'b0;
        check("R7 no standby", int'(mode), 4);
        check("R7 disq pulse 2", int'(ref_disq), 1);
        step();
        check("R10 ref valid", int'(mode), 5);
        // R3 collision: lock with acquisition timeout
        ticks(TO_S - 1);
        sec_tick = 1'b1; lock_ind = 1'b1; step(); sec_tick = 1'b0;
        check("R3 lock wins", int'(mode), 2);
        phase_err = 12'd0;
        // R11
        hp_restored = 1'b1; step(); hp_restored = 1'b0;
        check("R11 ignored", int'(mode), 2);
        revert_en = 1'b1; hp_restored = 1'b1; step(); hp_restored = 1'b0;
        check("R11 revert", int'(mode), 5);
        step();
        check("R3 reacquired", int'(mode), 2);
        // R8 priority
        ref_valid = 1'b0; hp_restored = 1'b1; phase_err = 12'd300; step();
        hp_restored = 1'b0;
        check("R8 holdover", int'(mode), 4);
        step(2);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule